// File: doc/BRIEF.md
# External Interrupt Detector with Vectoring

This block watches four external interrupt pins of a small 8-bit controller and turns activity on them into a single vectored request for the CPU. Every pin is synchronised to the core clock. Its edges or levels are then compared against a trigger mode that software selects for each source. A matching event sets that source's pending flag. The enabled pending source with the highest priority is offered to the CPU, together with its fixed vector address.

The sources are not all alike. Sources 0 and 1 accept single-edge or level triggers and can wake the controller from its deepest standby mode. Sources 2 and 3 accept single edges or both edges, and they share one event-count strobe that drives a timer input. Source 3 also passes through a digital noise filter. That filter samples either once per clock or once per sixteen clocks.

The CPU takes a vector through a valid/ready handshake. `irq_valid` high means `irq_vector` names an enabled pending source, and a transfer happens on a rising clock edge where `irq_valid` and `irq_ready` are both high. The CPU may hold `irq_ready` low for any number of cycles. All pending flags are kept while it does. The vector can still change in that time, because it always tracks the current best request: a higher-priority source that becomes pending takes over, and `irq_valid` drops if the offered request goes away.

Top module: `ext_irq_vector`

## Requirements
- R1: After reset, `pend_flags`, `irq_valid`, `tmr_evt` and `wake_req` are all 0.
- R2: Each source has a 3-bit mode field, `trig_mode[3i+2:3i]`. The codes are 0 = rising edge, 1 = falling edge, 2 = both edges, 3 = high level and 4 = low level. The vector for source i is 8*i + 3, so sources 0 to 3 give 03h, 0Bh, 13h and 1Bh.
- R3: For sources 0 to 2, a pin change driven between two clock edges appears in `pend_flags` after the third following rising edge: two synchroniser stages, then the pending register. `irq_valid` and `irq_vector` follow one edge after the pending flags.
- R4: An edge-triggered pending flag stays set until a handshake transfers its vector. The handshake clears it unless a new matching edge arrives on the same edge, in which case the new edge wins. After a handshake, `irq_valid` does not offer the same source in the next cycle.
- R5: A level-triggered pending flag follows the active level of its synchronised pin. A handshake does not clear it, so after a one-cycle gap the request is offered again while the level persists.
- R6: Modes a source does not support never set its pending flag and never cause a count strobe. For sources 0 and 1 these are codes 2, 5, 6 and 7. For sources 2 and 3 they are codes 3 to 7.
- R7: A pending flag sets whether or not its bit in `src_en` is high. Only pending sources that are enabled take part in `irq_valid` and `irq_vector`. A change of enable takes effect one edge later.
- R8: Priority is fixed: source 0 is highest and source 3 is lowest. When the offered source is cleared, the next enabled pending source is offered.
- R9: Source 3's filtered level changes only after two consecutive filter samples that agree with each other and differ from the current filtered level. With `filt_slow` = 0 the filter samples every clock. With `filt_slow` = 1 it samples once every 16 clocks, on a free-running divider that starts at reset. A 1-cycle pulse is therefore rejected and a 2-cycle pulse accepted in fast mode. In slow mode an 8-cycle pulse is rejected and a 32-cycle pulse accepted.
- R10: `tmr_evt` is a one-cycle strobe. It fires on the same edge at which a matching edge on source 2 or 3 sets the pending flag, whatever the enable bits hold.
- R11: `wake_req` is high in the cycle after source 0 or source 1 is both pending and enabled. Sources 2 and 3 never raise it.
- R12: While `irq_valid` is high and `irq_ready` is low, the offered vector and every pending flag stay unchanged unless the pins, modes or enables change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; one period is one instruction cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin | input | 4 | External interrupt pins, asynchronous to the clock |
| trig_mode | input | 12 | 3-bit trigger mode per source, source i at bits 3i+2:3i |
| src_en | input | 4 | Enable bit per source |
| filt_slow | input | 1 | Source 3 filter rate: 0 = every clock, 1 = every 16th clock |
| irq_valid | output | 1 | A vector is offered |
| irq_ready | input | 1 | The CPU accepts the offered vector |
| irq_vector | output | 8 | Vector address of the offered source |
| pend_flags | output | 4 | Pending flag per source |
| tmr_evt | output | 1 | One-cycle timer count strobe from source 2 or 3 |
| wake_req | output | 1 | Wake-up request from source 0 or 1 |

## Verification
The hardest case to reach is the source 3 filter in slow mode. Whether a pulse is accepted there depends on where the pulse falls relative to the free-running divide-by-16 phase, and that phase cannot be seen at the ports. The stimulus therefore uses pulse widths whose outcome does not depend on the phase: 8 cycles can never cover two samples, and 32 cycles always covers two. A behavioural model that counts the divider from reset checks every cycle in between. A second hard case is a level source and an edge source pending together. Handshakes are issued back to back there, to show that one flag survives acknowledgement and the other does not.

// File: rtl/eiv_pkg.sv
package eiv_pkg;

  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    TRIG_RISE = 3'd0,
    TRIG_FALL = 3'd1,
    TRIG_BOTH = 3'd2,
    TRIG_HIGH = 3'd3,
    TRIG_LOW  = 3'd4
  } trig_mode_e;

  // Legal code set differs between level-capable and edge-only sources
  function automatic logic mode_supported(input logic level_cap,
                                          input logic [MODE_W-1:0] m);
    if (level_cap)
      return (m == TRIG_RISE) || (m == TRIG_FALL) ||
             (m == TRIG_HIGH) || (m == TRIG_LOW);
    else
      return (m == TRIG_RISE) || (m == TRIG_FALL) || (m == TRIG_BOTH);
  endfunction

  function automatic logic mode_is_level(input logic [MODE_W-1:0] m);
    return (m == TRIG_HIGH) || (m == TRIG_LOW);
  endfunction

endpackage

// File: rtl/eiv_sync.sv
module eiv_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= async_i;
      stab_q <= meta_q;
    end
  end

  assign sync_o = stab_q;

endmodule

// File: rtl/eiv_noise_filter.sv
module eiv_noise_filter #(
  parameter int DEPTH    = 2,
  parameter int DIV_LOG2 = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  input  logic slow_i,
  output logic lvl_o
);

  localparam int CNT_W = (DEPTH > 1) ? $clog2(DEPTH + 1) : 1;

  logic [DIV_LOG2-1:0] pre_q;
  logic [CNT_W-1:0]    cnt_q;
  logic                lvl_q;
  logic                tick;

  assign tick = !slow_i || (&pre_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      pre_q <= pre_q + 1'b1;
      if (tick) begin
        if (raw_i == lvl_q) begin
          cnt_q <= '0;
        end else if (cnt_q == CNT_W'(DEPTH - 1)) begin
          lvl_q <= raw_i;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign lvl_o = lvl_q;

  AST_FILT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl_q) |-> (lvl_q == $past(raw_i))); // R9

endmodule

// File: rtl/eiv_trigger.sv
module eiv_trigger
  import eiv_pkg::*;
#(
  parameter bit LEVEL_CAP = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lvl_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              ack_i,
  output logic              pend_o,
  output logic              edge_hit_o
);

  logic prev_q, pend_q, pend_d;
  logic rise, fall, hit, ok, is_lvl;

  always_comb begin
    rise   = lvl_i && !prev_q;
    fall   = !lvl_i && prev_q;
    ok     = mode_supported(LEVEL_CAP, mode_i);
    is_lvl = ok && mode_is_level(mode_i);
    case (mode_i)
      TRIG_RISE: hit = rise;
      TRIG_FALL: hit = fall;
      TRIG_BOTH: hit = rise || fall;
      TRIG_HIGH: hit = lvl_i;
      TRIG_LOW:  hit = !lvl_i;
      default:   hit = 1'b0;
    endcase
    if (!ok)         pend_d = 1'b0;
    else if (is_lvl) pend_d = hit;
    else if (hit)    pend_d = 1'b1;
    else if (ack_i)  pend_d = 1'b0;
    else             pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o     = pend_q;
  assign edge_hit_o = ok && !is_lvl && hit;

  AST_BAD_MODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ok |=> !pend_q); // R6
  AST_LEVEL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (is_lvl && hit) |=> pend_q); // R5

endmodule

// File: rtl/eiv_arbiter.sv
module eiv_arbiter #(
  parameter int N          = 4,
  parameter int VEC_W      = 8,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     pend_i,
  input  logic [N-1:0]     en_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [VEC_W-1:0] vector_o,
  output logic [N-1:0]     ack_o
);

  localparam int SRC_W = (N > 1) ? $clog2(N) : 1;
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  logic [N-1:0]     req;
  logic [SRC_W-1:0] sel;
  logic [SRC_W-1:0] src_q;
  logic             valid_q;

  always_comb begin
    ack_o = '0;
    if (valid_q && ready_i) ack_o = ONE << src_q;
    req = pend_i & en_i & ~ack_o;
    sel = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) sel = SRC_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      src_q   <= '0;
    end else begin
      valid_q <= |req;
      if (|req) src_q <= sel;
    end
  end

  assign valid_o  = valid_q;
  assign vector_o = VEC_W'(VEC_BASE) + VEC_W'(VEC_STRIDE) * VEC_W'(src_q);

  AST_ACK_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && ready_i) |=> !(valid_q && (src_q == $past(src_q)))); // R4
  AST_VALID_FROM_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> |($past(pend_i & en_i) & (ONE << src_q))); // R7

endmodule

// File: rtl/ext_irq_vector.sv
module ext_irq_vector
  import eiv_pkg::*;
#(
  parameter int N_SRC      = 4,
  parameter int N_LEVEL    = 2,
  parameter int FILT_DEPTH = 2,
  parameter int DIV_LOG2   = 4,
  parameter int VEC_W      = 8,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_SRC-1:0]          irq_pin,
  input  logic [MODE_W*N_SRC-1:0]   trig_mode,
  input  logic [N_SRC-1:0]          src_en,
  input  logic                      filt_slow,
  output logic                      irq_valid,
  input  logic                      irq_ready,
  output logic [VEC_W-1:0]          irq_vector,
  output logic [N_SRC-1:0]          pend_flags,
  output logic                      tmr_evt,
  output logic                      wake_req
);

  localparam logic [N_SRC-1:0] LVL_MASK  = {N_SRC{1'b1}} >> (N_SRC - N_LEVEL);
  localparam logic [N_SRC-1:0] EDGE_MASK = ~LVL_MASK;

  logic [N_SRC-1:0] sync_lvl;
  logic [N_SRC-1:0] det_lvl;
  logic [N_SRC-1:0] pend;
  logic [N_SRC-1:0] edge_hit;
  logic [N_SRC-1:0] ack;
  logic             filt_lvl;
  logic             evt_q, wake_q;

  eiv_sync #(.W(N_SRC)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (irq_pin),
    .sync_o  (sync_lvl)
  );

  eiv_noise_filter #(.DEPTH(FILT_DEPTH), .DIV_LOG2(DIV_LOG2)) u_filt (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (sync_lvl[N_SRC-1]),
    .slow_i (filt_slow),
    .lvl_o  (filt_lvl)
  );

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    if (i == N_SRC - 1) begin : g_filtered
      assign det_lvl[i] = filt_lvl;
    end else begin : g_direct
      assign det_lvl[i] = sync_lvl[i];
    end
    eiv_trigger #(.LEVEL_CAP(i < N_LEVEL)) u_trig (
      .clk        (clk),
      .rst_n      (rst_n),
      .lvl_i      (det_lvl[i]),
      .mode_i     (trig_mode[MODE_W*i +: MODE_W]),
      .ack_i      (ack[i]),
      .pend_o     (pend[i]),
      .edge_hit_o (edge_hit[i])
    );
  end

  eiv_arbiter #(
    .N(N_SRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
  ) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend_i   (pend),
    .en_i     (src_en),
    .ready_i  (irq_ready),
    .valid_o  (irq_valid),
    .vector_o (irq_vector),
    .ack_o    (ack)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      evt_q  <= |(edge_hit & EDGE_MASK);
      wake_q <= |(pend & src_en & LVL_MASK);
    end
  end

  assign tmr_evt    = evt_q;
  assign wake_req   = wake_q;
  assign pend_flags = pend;

  AST_HOLD_UNDER_BP: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_ready && $stable(irq_pin) && $stable(trig_mode) &&
     $stable(src_en) && $stable(sync_lvl) && $stable(filt_lvl))
    |=> (pend_flags == $past(pend_flags))); // R12

endmodule

// File: tb/test_ext_irq_vector.sv
`timescale 1ns/1ps
module test_ext_irq_vector;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  irq_pin = '0;
  logic [11:0] trig_mode = '0;
  logic [3:0]  src_en = '0;
  logic        filt_slow = 1'b0;
  logic        irq_ready = 1'b0;
  logic        irq_valid;
  logic [7:0]  irq_vector;
  logic [3:0]  pend_flags;
  logic        tmr_evt, wake_req;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  ext_irq_vector i_ext_irq_vector (
    .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin), .trig_mode(trig_mode),
    .src_en(src_en), .filt_slow(filt_slow), .irq_valid(irq_valid),
    .irq_ready(irq_ready), .irq_vector(irq_vector), .pend_flags(pend_flags),
    .tmr_evt(tmr_evt), .wake_req(wake_req)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(input int s, input logic [2:0] m);
    trig_mode[3*s +: 3] = m;
  endtask

  // Behavioural reference model, advanced on each rising edge
  logic [3:0] m_s1, m_s2, m_prev, m_pend;
  logic       m_f, m_valid, m_evt, m_wake;
  int         m_cnt, m_pre, m_src;

  function automatic bit legal(input int s, input int md);
    if (s < 2) return (md == 0) || (md == 1) || (md == 3) || (md == 4);
    return md <= 2;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_pend = '0;
      m_f = 0; m_valid = 0; m_evt = 0; m_wake = 0;
      m_cnt = 0; m_pre = 0; m_src = 0;
    end else begin
      logic [3:0] lv, ackv, np, rq;
      bit nevt, tick;
      lv = {m_f, m_s2[2:0]};
      ackv = (m_valid && irq_ready) ? (4'b0001 << m_src) : 4'b0000;
      nevt = 0;
      for (int s = 0; s < 4; s++) begin
        int md;
        bit r, f, h;
        md = int'(trig_mode[3*s +: 3]);
        r = lv[s] && !m_prev[s];
        f = !lv[s] && m_prev[s];
        case (md)
          0: h = r;
          1: h = f;
          2: h = r || f;
          3: h = lv[s];
          4: h = !lv[s];
          default: h = 0;
        endcase
        if (!legal(s, md)) np[s] = 0;
        else if (md >= 3) np[s] = h;
        else if (h) np[s] = 1;
        else if (ackv[s]) np[s] = 0;
        else np[s] = m_pend[s];
        if (legal(s, md) && md <= 2 && h && s >= 2) nevt = 1;
      end
      rq = m_pend & src_en & ~ackv;
      m_wake = |(m_pend[1:0] & src_en[1:0]);
      m_valid = |rq;
      for (int s = 3; s >= 0; s--) if (rq[s]) m_src = s;
      m_evt = nevt;
      m_pend = np;
      tick = !filt_slow || (m_pre == 15);
      if (tick) begin
        if (m_s2[3] == m_f) m_cnt = 0;
        else if (m_cnt == 1) begin m_f = m_s2[3]; m_cnt = 0; end
        else m_cnt++;
      end
      m_pre = (m_pre + 1) % 16;
      m_prev = lv;
      m_s2 = m_s1;
      m_s1 = irq_pin;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(pend_flags == m_pend, "R3 pend model", pend_flags, m_pend);
      chk(irq_valid == m_valid, "R8 valid model", irq_valid, m_valid);
      if (m_valid) chk(irq_vector == 8'(8*m_src + 3), "R2 vector model", irq_vector, 8*m_src + 3);
      chk(tmr_evt == m_evt, "R10 evt model", tmr_evt, m_evt);
      chk(wake_req == m_wake, "R11 wake model", wake_req, m_wake);
    end
  end

  initial begin
    #(4 * 100000);
    n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    step(4);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk(pend_flags == 0 && !irq_valid && !tmr_evt && !wake_req, "R1 reset", {pend_flags, irq_valid, tmr_evt, wake_req}, 0);
    src_en = 4'hF;

    // R3, R2, R11, R12, R4 with source 0 rising edge
    irq_pin[0] = 1'b1;
    step(3);
    chk(pend_flags == 4'b0001, "R3 latency", pend_flags, 1);
    step(1);
    chk(irq_valid && irq_vector == 8'h03, "R2 vector src0", irq_vector, 8'h03);
    chk(wake_req, "R11 wake", wake_req, 1);
    step(5);
    chk(irq_valid && irq_vector == 8'h03 && pend_flags == 4'b0001, "R12 backpressure hold", irq_vector, 8'h03);
    irq_ready = 1'b1;
    step(1);
    chk(pend_flags == 0 && !irq_valid, "R4 ack clears", {pend_flags, irq_valid}, 0);
    irq_ready = 1'b0;
    irq_pin[0] = 1'b0;
    step(4);

    // R8, R5 level src1 with both-edge src2
    set_mode(1, 3'd3);
    set_mode(2, 3'd2);
    irq_pin[2:1] = 2'b11;
    step(4);
    chk(irq_valid && irq_vector == 8'h0B, "R8 priority", irq_vector, 8'h0B);
    irq_ready = 1'b1;
    step(1);
    chk(pend_flags == 4'b0110 && irq_vector == 8'h13, "R5 level survives ack", {pend_flags, irq_vector}, {4'b0110, 8'h13});
    step(1);
    chk(pend_flags == 4'b0010 && irq_valid && irq_vector == 8'h0B, "R5 level reoffered", {pend_flags, irq_vector}, {4'b0010, 8'h0B});
    irq_ready = 1'b0;
    irq_pin[2:1] = 2'b00;
    step(4);
    chk(irq_valid && irq_vector == 8'h13, "R8 falling edge src2", irq_vector, 8'h13);
    irq_ready = 1'b1;
    step(1);
    chk(pend_flags == 0, "R4 drain", pend_flags, 0);
    irq_ready = 1'b0;

    // R6 unsupported modes
    set_mode(0, 3'd2);
    set_mode(2, 3'd3);
    irq_pin[0] = 1'b1; irq_pin[2] = 1'b1;
    step(4);
    chk(pend_flags == 0 && !irq_valid, "R6 illegal mode rise", pend_flags, 0);
    irq_pin[0] = 1'b0; irq_pin[2] = 1'b0;
    step(4);
    chk(pend_flags == 0, "R6 illegal mode fall", pend_flags, 0);
    set_mode(0, 3'd0); set_mode(1, 3'd0); set_mode(2, 3'd0);
    step(2);

    // R7 enable gating
    src_en = 4'b1110;
    irq_pin[0] = 1'b1;
    step(4);
    chk(pend_flags[0] && !irq_valid, "R7 disabled pending", {pend_flags, irq_valid}, 5'b00010);
    src_en = 4'hF;
    step(1);
    chk(irq_valid && irq_vector == 8'h03, "R7 enable late", irq_vector, 8'h03);
    irq_ready = 1'b1;
    step(1);
    irq_ready = 1'b0;
    irq_pin[0] = 1'b0;
    step(3);

    // R9 fast filter, R10 strobe
    irq_pin[3] = 1'b1;
    step(1);
    irq_pin[3] = 1'b0;
    step(8);
    chk(!pend_flags[3], "R9 fast 1-cycle reject", pend_flags[3], 0);
    irq_pin[3] = 1'b1;
    step(2);
    irq_pin[3] = 1'b0;
    step(3);
    chk(tmr_evt && pend_flags[3], "R10 strobe src3", {tmr_evt, pend_flags[3]}, 2'b11);
    irq_ready = 1'b1;
    step(2);
    irq_ready = 1'b0;

    // R9 slow filter
    filt_slow = 1'b1;
    irq_pin[3] = 1'b1;
    step(8);
    irq_pin[3] = 1'b0;
    step(40);
    chk(!pend_flags[3], "R9 slow 8-cycle reject", pend_flags[3], 0);
    irq_pin[3] = 1'b1;
    step(32);
    irq_pin[3] = 1'b0;
    step(40);
    chk(pend_flags[3], "R9 slow 32-cycle accept", pend_flags[3], 1);
    irq_ready = 1'b1;
    step(2);
    irq_ready = 1'b0;
    filt_slow = 1'b0;
    step(40);

    // R10 strobe ignores enable
    src_en = 4'b1011;
    irq_pin[2] = 1'b1;
    step(3);
    chk(tmr_evt, "R10 strobe disabled src2", tmr_evt, 1);
    step(1);
    chk(!irq_valid && !tmr_evt, "R10 one cycle, no request", {irq_valid, tmr_evt}, 0);
    irq_pin[2] = 1'b0;
    step(4);
    src_en = 4'hF;
    irq_ready = 1'b1;
    step(4);
    irq_ready = 1'b0;
    step(5);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule